// File: doc/BRIEF.md
# System Exception State Register Block

This block holds the pending, active and enable state of the eight fixed system exceptions: non-maskable interrupt, memory-management fault, bus fault, usage fault, supervisor call, debug monitor, deferred service call and periodic timer tick. Software reaches it through a word-wide register port. Two registers expose the exception state. An interrupt control/state word packs the active vector, the highest pending vector and a set of summary flags. A handler control/status word shows per-exception active and pending bits and the three fault enables. The same port also serves a vector table base register, a key-protected application reset control register and a software trigger register that pends an external interrupt.

Hardware sources raise pending through one-cycle pulses. An external prioritiser supplies the active vector number, the highest pending vector number and a flag that says whether the active exception preempted another one. It reports taking an exception with a take pulse and leaving it with a return pulse. The prioritiser does the arbitration. This block only holds and reports the state. All vector numbers use the hardware numbering: external interrupts start at 16, and the fixed exceptions are NMI 2, memory fault 4, bus fault 5, usage fault 6, supervisor call 11, debug monitor 12, deferred service 14 and timer tick 15.

Top module: `sysexc_regs`

## Requirements
- R1: After reset, nothing is pending or active. The three fault enables are 0, the vector base reads 0, `reset_req` and `sw_trig_valid` are low, `sys_en` is 8'hF1, and an access to an unmapped offset (for example 0xD10) reads 0.
- R2: A write to offset 0xD04 with bit 31 set makes NMI pending. Bit 28 makes the deferred service call pending and bit 26 makes the timer tick pending. The new state is visible from the cycle after the write. The bit order of `sys_pend` and `sys_en` is NMI 0, memory 1, bus 2, usage 3, supervisor 4, debug 5, deferred service 6, timer tick 7.
- R3: In a write to 0xD04, bit 27 clears deferred-service pending and bit 25 clears timer-tick pending. Each clear is ignored when the matching set bit (28 or 26) is also 1 in the same write. NMI pending cannot be cleared by a write.
- R4: A read of 0xD04 returns `act_vec` in bits 8:0 and `pend_vec` in bits 20:12. Bit 11 is 1 when `act_vec` is 0 or `act_preempted` is 0. Bit 22 reflects `ext_pend_any`. Bits 26, 28 and 31 reflect timer-tick, deferred-service and NMI pending.
- R5: A pulse on `hw_pend_set[i]` makes exception i pending in the next cycle. It wins over a register clear or a take of the same exception in the same cycle.
- R6: A take pulse with a system exception's vector clears that exception's pending state and sets its active state. A return pulse with that vector clears its active state.
- R7: A read of 0xD24 shows active state at bit 0 (memory), 1 (bus), 3 (usage), 7 (supervisor), 8 (debug), 10 (deferred service) and 11 (timer tick).
- R8: A read of 0xD24 shows pending state at bit 12 (usage), 13 (memory), 14 (bus) and 15 (supervisor).
- R9: Bits 16, 17 and 18 of a write to 0xD24 set the memory, bus and usage fault enables. They read back in the same positions and drive `sys_en[1]`, `sys_en[2]` and `sys_en[3]`. The other `sys_en` bits are always 1.
- R10: A write to 0xD08 stores bits 31:7 and forces bits 6:0 to zero. The value reads back at 0xD08 and drives `vtor`.
- R11: Offset 0xD0C always reads 0x0FA05000. A write there acts only when bits 31:16 equal 0x05FA. With the key, bit 1 clears every active state, and bit 0 or bit 2 gives a one-cycle `reset_req` pulse in the following cycle.
- R12: A write to 0xF00 whose bits 8:0 hold a number below `NUM_IRQ` gives a one-cycle `sw_trig_valid` pulse in the following cycle, with that number on `sw_trig_irq`. Larger numbers produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_pend_set | input | 8 | Per-exception set-pending pulses |
| take_valid | input | 1 | Prioritiser takes the exception in `take_vec` |
| take_vec | input | 9 | Vector being taken |
| ret_valid | input | 1 | Prioritiser returns from the exception in `ret_vec` |
| ret_vec | input | 9 | Vector being returned from |
| act_vec | input | 9 | Currently active vector, 0 when none |
| act_preempted | input | 1 | Active exception has a preempted one beneath it |
| pend_vec | input | 9 | Highest pending vector |
| ext_pend_any | input | 1 | Some external interrupt is pending |
| sys_pend | output | 8 | Per-exception pending state |
| sys_en | output | 8 | Per-exception enable |
| vtor | output | 32 | Vector table base |
| reset_req | output | 1 | System reset request pulse |
| sw_trig_valid | output | 1 | Software interrupt trigger pulse |
| sw_trig_irq | output | 9 | External interrupt number to pend |

## Verification
Two functions can act on the same pending bit in one cycle: a hardware set-pending pulse, and either a register clear or a prioritiser take. A register write can also carry a set bit and a clear bit for the same exception. The bench provokes both cases by driving the clear write (or the take pulse) in the same cycle as `hw_pend_set`, and by writing bit pairs 28/27 and 26/25 together. It judges the result from `sys_pend` and the 0xD04 read word in the next cycle, where the set must have won.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;

    localparam int NUM_SYS = 8;
    localparam int VEC_W   = 9;

    typedef enum logic [2:0] {
        EX_NMI  = 3'd0,
        EX_MEM  = 3'd1,
        EX_BUS  = 3'd2,
        EX_USE  = 3'd3,
        EX_SVC  = 3'd4,
        EX_DBG  = 3'd5,
        EX_PSV  = 3'd6,
        EX_TICK = 3'd7
    } exc_e;

    localparam logic [11:0] OFS_STATE  = 12'hD04;
    localparam logic [11:0] OFS_VBASE  = 12'hD08;
    localparam logic [11:0] OFS_RSTCTL = 12'hD0C;
    localparam logic [11:0] OFS_HANDLR = 12'hD24;
    localparam logic [11:0] OFS_TRIG   = 12'hF00;

    localparam logic [15:0] RST_KEY    = 16'h05FA;
    localparam logic [31:0] RSTCTL_RD  = 32'h0FA05000;

    typedef struct packed {
        logic [NUM_SYS-1:0] set;
        logic [NUM_SYS-1:0] clr;
        logic               en_we;
        logic [2:0]         en_val;
        logic               clr_active;
        logic               rst_req;
        logic               vbase_we;
        logic [31:0]        vbase_val;
        logic               trig;
        logic [VEC_W-1:0]   trig_irq;
    } wr_cmd_t;

    // Hardware vector number of each fixed exception slot
    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        case (idx)
            0:       return 9'd2;
            1:       return 9'd4;
            2:       return 9'd5;
            3:       return 9'd6;
            4:       return 9'd11;
            5:       return 9'd12;
            6:       return 9'd14;
            default: return 9'd15;
        endcase
    endfunction

endpackage

// File: rtl/sysexc_wr_decode.sv
module sysexc_wr_decode
    import sysexc_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output wr_cmd_t     cmd
);
    localparam logic [VEC_W:0] IRQ_LIM = (VEC_W+1)'(NUM_IRQ);

    logic wr_state, wr_rst_ok;

    always_comb begin
        wr_state  = bus_wr && (bus_addr == OFS_STATE);
        wr_rst_ok = bus_wr && (bus_addr == OFS_RSTCTL) && (bus_wdata[31:16] == RST_KEY);
        cmd = '0;
        // set requests
        cmd.set[EX_NMI]  = wr_state && bus_wdata[31];
        cmd.set[EX_PSV]  = wr_state && bus_wdata[28];
        cmd.set[EX_TICK] = wr_state && bus_wdata[26];
        // clear requests lose to a set of the same exception in the same word
        cmd.clr[EX_PSV]  = wr_state && bus_wdata[27] && !bus_wdata[28];
        cmd.clr[EX_TICK] = wr_state && bus_wdata[25] && !bus_wdata[26];
        cmd.en_we        = bus_wr && (bus_addr == OFS_HANDLR);
        cmd.en_val       = bus_wdata[18:16];
        cmd.clr_active   = wr_rst_ok && bus_wdata[1];
        cmd.rst_req      = wr_rst_ok && (bus_wdata[2] || bus_wdata[0]);
        cmd.vbase_we     = bus_wr && (bus_addr == OFS_VBASE);
        cmd.vbase_val    = {bus_wdata[31:7], 7'b0};
        cmd.trig_irq     = bus_wdata[8:0];
        cmd.trig         = bus_wr && (bus_addr == OFS_TRIG) &&
                           ({1'b0, bus_wdata[8:0]} < IRQ_LIM);
    end
endmodule

// File: rtl/sysexc_state.sv
module sysexc_state
    import sysexc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_cmd_t            cmd,
    input  logic [NUM_SYS-1:0] hw_set,
    input  logic               take_valid,
    input  logic [VEC_W-1:0]   take_vec,
    input  logic               ret_valid,
    input  logic [VEC_W-1:0]   ret_vec,
    output logic [NUM_SYS-1:0] pend,
    output logic [NUM_SYS-1:0] act,
    output logic [NUM_SYS-1:0] en
);
    for (genvar i = 0; i < NUM_SYS; i++) begin : g_exc
        logic p_q, a_q, hit_take, hit_ret;

        assign hit_take = take_valid && (take_vec == vec_of(i));
        assign hit_ret  = ret_valid  && (ret_vec  == vec_of(i));

        always_ff @(posedge clk) begin
            if (rst)                              p_q <= 1'b0;
            else if (hw_set[i] || cmd.set[i])     p_q <= 1'b1;
            else if (cmd.clr[i] || hit_take)      p_q <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)                              a_q <= 1'b0;
            else if (hit_take)                    a_q <= 1'b1;
            else if (hit_ret || cmd.clr_active)   a_q <= 1'b0;
        end

        assign pend[i] = p_q;
        assign act[i]  = a_q;

        if (i >= int'(EX_MEM) && i <= int'(EX_USE)) begin : g_fault_en
            logic e_q;
            always_ff @(posedge clk) begin
                if (rst)            e_q <= 1'b0;
                else if (cmd.en_we) e_q <= cmd.en_val[i-1];
            end
            assign en[i] = e_q;
        end else begin : g_fixed_en
            assign en[i] = 1'b1;
        end
    end
endmodule

// File: rtl/sysexc_rd_mux.sv
module sysexc_rd_mux
    import sysexc_pkg::*;
(
    input  logic [11:0]        bus_addr,
    input  logic [NUM_SYS-1:0] pend,
    input  logic [NUM_SYS-1:0] act,
    input  logic [NUM_SYS-1:0] en,
    input  logic [VEC_W-1:0]   act_vec,
    input  logic               act_preempted,
    input  logic [VEC_W-1:0]   pend_vec,
    input  logic               ext_pend_any,
    input  logic [31:0]        vbase,
    output logic [31:0]        rdata
);
    logic [31:0] state_w, handlr_w;

    always_comb begin
        state_w         = '0;
        state_w[8:0]    = act_vec;
        state_w[11]     = (act_vec == '0) || !act_preempted;
        state_w[20:12]  = pend_vec;
        state_w[22]     = ext_pend_any;
        state_w[26]     = pend[EX_TICK];
        state_w[28]     = pend[EX_PSV];
        state_w[31]     = pend[EX_NMI];

        handlr_w        = '0;
        handlr_w[0]     = act[EX_MEM];
        handlr_w[1]     = act[EX_BUS];
        handlr_w[3]     = act[EX_USE];
        handlr_w[7]     = act[EX_SVC];
        handlr_w[8]     = act[EX_DBG];
        handlr_w[10]    = act[EX_PSV];
        handlr_w[11]    = act[EX_TICK];
        handlr_w[12]    = pend[EX_USE];
        handlr_w[13]    = pend[EX_MEM];
        handlr_w[14]    = pend[EX_BUS];
        handlr_w[15]    = pend[EX_SVC];
        handlr_w[16]    = en[EX_MEM];
        handlr_w[17]    = en[EX_BUS];
        handlr_w[18]    = en[EX_USE];

        case (bus_addr)
            OFS_STATE:  rdata = state_w;
            OFS_HANDLR: rdata = handlr_w;
            OFS_VBASE:  rdata = vbase;
            OFS_RSTCTL: rdata = RSTCTL_RD;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/sysexc_regs.sv
module sysexc_regs
    import sysexc_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SYS-1:0] hw_pend_set,
    input  logic               take_valid,
    input  logic [VEC_W-1:0]   take_vec,
    input  logic               ret_valid,
    input  logic [VEC_W-1:0]   ret_vec,
    input  logic [VEC_W-1:0]   act_vec,
    input  logic               act_preempted,
    input  logic [VEC_W-1:0]   pend_vec,
    input  logic               ext_pend_any,
    output logic [NUM_SYS-1:0] sys_pend,
    output logic [NUM_SYS-1:0] sys_en,
    output logic [31:0]        vtor,
    output logic               reset_req,
    output logic               sw_trig_valid,
    output logic [VEC_W-1:0]   sw_trig_irq
);
    wr_cmd_t            cmd;
    logic [NUM_SYS-1:0] act;

    sysexc_wr_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmd       (cmd)
    );

    sysexc_state u_state (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .hw_set     (hw_pend_set),
        .take_valid (take_valid),
        .take_vec   (take_vec),
        .ret_valid  (ret_valid),
        .ret_vec    (ret_vec),
        .pend       (sys_pend),
        .act        (act),
        .en         (sys_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vtor          <= '0;
            reset_req     <= 1'b0;
            sw_trig_valid <= 1'b0;
            sw_trig_irq   <= '0;
        end else begin
            if (cmd.vbase_we) vtor <= cmd.vbase_val;
            reset_req     <= cmd.rst_req;
            sw_trig_valid <= cmd.trig;
            if (cmd.trig) sw_trig_irq <= cmd.trig_irq;
        end
    end

    sysexc_rd_mux u_rd (
        .bus_addr      (bus_addr),
        .pend          (sys_pend),
        .act           (act),
        .en            (sys_en),
        .act_vec       (act_vec),
        .act_preempted (act_preempted),
        .pend_vec      (pend_vec),
        .ext_pend_any  (ext_pend_any),
        .vbase         (vtor),
        .rdata         (bus_rdata)
    );
endmodule

// File: rtl/sysexc_regs_chk.sv
module sysexc_regs_chk
    import sysexc_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [11:0]        bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [NUM_SYS-1:0] hw_pend_set,
    input logic               take_valid,
    input logic [VEC_W-1:0]   take_vec,
    input logic [NUM_SYS-1:0] sys_pend,
    input logic [31:0]        vtor,
    input logic               reset_req,
    input logic               sw_trig_valid,
    input logic [VEC_W-1:0]   sw_trig_irq
);
    localparam logic [VEC_W:0] IRQ_LIM = (VEC_W+1)'(NUM_IRQ);

    assert_nmi_set_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'hD04 && bus_wdata[31]) |=> sys_pend[0]);

    assert_psv_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'hD04 && bus_wdata[27] && !bus_wdata[28] && !hw_pend_set[6])
        |=> !sys_pend[6]);

    assert_hw_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (|hw_pend_set) |=> ((sys_pend & $past(hw_pend_set)) == $past(hw_pend_set)));

    assert_take_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (take_valid && take_vec == 9'd15 && !hw_pend_set[7] &&
         !(bus_wr && bus_addr == 12'hD04 && bus_wdata[26])) |=> !sys_pend[7]);

    assert_vbase_align_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'hD08) |=> (vtor == {$past(bus_wdata[31:7]), 7'b0}));

    assert_reset_key_R11: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(bus_wr && bus_addr == 12'hD0C && bus_wdata[31:16] == 16'h05FA &&
                            (bus_wdata[2] || bus_wdata[0])));

    assert_clr_only_no_reset_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'hD0C && bus_wdata[2:0] == 3'b010) |=> !reset_req);

    assert_trig_range_R12: assert property (@(posedge clk) disable iff (rst)
        sw_trig_valid |-> (({1'b0, sw_trig_irq} < IRQ_LIM) &&
                           sw_trig_irq == $past(bus_wdata[8:0])));
endmodule

bind sysexc_regs sysexc_regs_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (.*);

// File: tb/sysexc_regs_bench.sv
module sysexc_regs_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  hw_pend_set = '0;
    logic        take_valid = 1'b0;
    logic [8:0]  take_vec = '0;
    logic        ret_valid = 1'b0;
    logic [8:0]  ret_vec = '0;
    logic [8:0]  act_vec = '0;
    logic        act_preempted = 1'b0;
    logic [8:0]  pend_vec = '0;
    logic        ext_pend_any = 1'b0;
    logic [7:0]  sys_pend, sys_en;
    logic [31:0] vtor;
    logic        reset_req, sw_trig_valid;
    logic [8:0]  sw_trig_irq;

    int checks = 0;
    int fails  = 0;
    logic p_rst, p_trig;
    logic [8:0] p_irq;

    always #5 clk = ~clk;

    sysexc_regs #(.NUM_IRQ(64)) u_sysexc_regs (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // drive one write cycle; other same-cycle stimuli are set by the caller
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        p_rst = reset_req; p_trig = sw_trig_valid; p_irq = sw_trig_irq;
    endtask

    task automatic take(input logic [8:0] v);
        take_valid = 1'b1; take_vec = v;
        @(negedge clk);
        take_valid = 1'b0;
    endtask

    task automatic hw_pulse(input logic [7:0] m);
        hw_pend_set = m;
        @(negedge clk);
        hw_pend_set = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(12'hD04, d); chk("R1 state word", d, 32'h0000_0800);
        rd(12'hD24, d); chk("R1 handler word", d, 32'h0);
        rd(12'hD08, d); chk("R1 vbase", d, 32'h0);
        rd(12'hD10, d); chk("R1 unmapped", d, 32'h0);
        chk("R1 sys_pend", {24'h0, sys_pend}, 32'h0);
        chk("R1 sys_en", {24'h0, sys_en}, 32'hF1);
        chk("R1 pulses", {30'h0, reset_req, sw_trig_valid}, 32'h0);
    endtask

    task automatic t_set;
        logic [31:0] d;
        wr(12'hD04, 32'h9400_0000);
        rd(12'hD04, d); chk("R2 set nmi/psv/tick", d, 32'h9400_0800);
        chk("R2 sys_pend", {24'h0, sys_pend}, 32'hC1);
    endtask

    task automatic t_clear;
        logic [31:0] d;
        wr(12'hD04, 32'h0A00_0000);
        rd(12'hD04, d); chk("R3 clear psv/tick, nmi kept", d, 32'h8000_0800);
        wr(12'hD04, 32'h1800_0000);
        rd(12'hD04, d); chk("R3 psv set beats clear", d, 32'h9000_0800);
        wr(12'hD04, 32'h0600_0000);
        rd(12'hD04, d); chk("R3 tick set beats clear", d, 32'h9400_0800);
        take(9'd2);
        chk("R6 take nmi clears pending", {24'h0, sys_pend}, 32'hC0);
    endtask

    task automatic t_fields;
        logic [31:0] d;
        act_vec = 9'd22; act_preempted = 1'b1; pend_vec = 9'd37; ext_pend_any = 1'b1;
        rd(12'hD04, d); chk("R4 fields nested", d & 32'h007F_FFFF, 32'h0042_5016);
        act_preempted = 1'b0;
        rd(12'hD04, d); chk("R4 base flag", d & 32'h007F_FFFF, 32'h0042_5816);
        act_vec = 9'd0; act_preempted = 1'b1; ext_pend_any = 1'b0; pend_vec = 9'd0;
        rd(12'hD04, d); chk("R4 none active", d & 32'h007F_FFFF, 32'h0000_0800);
    endtask

    task automatic t_race;
        wr(12'hD04, 32'h0A00_0000);
        chk("R3 clear both", {24'h0, sys_pend}, 32'h00);
        hw_pend_set = 8'h40;
        wr(12'hD04, 32'h0800_0000);
        hw_pend_set = '0;
        chk("R5 hw set beats write clear", {24'h0, sys_pend}, 32'h40);
        hw_pend_set = 8'h80;
        take(9'd15);
        hw_pend_set = '0;
        chk("R5 hw set beats take", {24'h0, sys_pend}, 32'hC0);
        wr(12'hD04, 32'h0800_0000);
        chk("R3 lone clear", {24'h0, sys_pend}, 32'h80);
    endtask

    task automatic t_handler;
        logic [31:0] d;
        wr(12'hD04, 32'h0200_0000);
        wr(12'hD0C, 32'h05FA_0002);
        chk("R11 clr-active gives no reset", {31'h0, p_rst}, 32'h0);
        rd(12'hD24, d); chk("R11 clean start", d, 32'h0);
        hw_pulse(8'h1E);
        rd(12'hD24, d); chk("R8 pending positions", d, 32'h0000_F000);
        take(9'd4); take(9'd5); take(9'd6); take(9'd11);
        hw_pulse(8'hE0);
        take(9'd12); take(9'd14); take(9'd15);
        rd(12'hD24, d); chk("R7 active positions", d, 32'h0000_0D8B);
        chk("R6 takes cleared pending", {24'h0, sys_pend}, 32'h00);
        ret_valid = 1'b1; ret_vec = 9'd4;
        @(negedge clk);
        ret_valid = 1'b0;
        rd(12'hD24, d); chk("R6 return clears active", d, 32'h0000_0D8A);
        wr(12'hD0C, 32'h0000_0002);
        rd(12'hD24, d); chk("R11 no key ignored", d, 32'h0000_0D8A);
        wr(12'hD0C, 32'h05FA_0002);
        rd(12'hD24, d); chk("R11 keyed clear active", d, 32'h0);
    endtask

    task automatic t_enables;
        logic [31:0] d;
        wr(12'hD24, 32'hFFF7_FFFF);
        rd(12'hD24, d); chk("R9 enables read back", d, 32'h0007_0000);
        chk("R9 sys_en all", {24'h0, sys_en}, 32'hFF);
        wr(12'hD24, 32'h0002_0000);
        rd(12'hD24, d); chk("R9 bus only", d, 32'h0002_0000);
        chk("R9 sys_en bus only", {24'h0, sys_en}, 32'hF5);
    endtask

    task automatic t_vbase;
        logic [31:0] d;
        wr(12'hD08, 32'h2000_01FF);
        rd(12'hD08, d); chk("R10 vbase read", d, 32'h2000_0180);
        chk("R10 vtor port", vtor, 32'h2000_0180);
    endtask

    task automatic t_rstctl;
        logic [31:0] d;
        wr(12'hD0C, 32'h05FA_0004);
        chk("R11 keyed reset pulse", {31'h0, p_rst}, 32'h1);
        @(negedge clk);
        chk("R11 pulse one cycle", {31'h0, reset_req}, 32'h0);
        wr(12'hD0C, 32'h05FA_0001);
        chk("R11 bit0 reset pulse", {31'h0, p_rst}, 32'h1);
        wr(12'hD0C, 32'h1234_0005);
        chk("R11 wrong key no pulse", {31'h0, p_rst}, 32'h0);
        rd(12'hD0C, d); chk("R11 constant read", d, 32'h0FA0_5000);
    endtask

    task automatic t_trig;
        wr(12'hF00, 32'h0000_003F);
        chk("R12 trig 63", {22'h0, p_trig, p_irq}, {22'h0, 1'b1, 9'd63});
        @(negedge clk);
        chk("R12 trig one cycle", {31'h0, sw_trig_valid}, 32'h0);
        wr(12'hF00, 32'h0000_0040);
        chk("R12 64 rejected", {31'h0, p_trig}, 32'h0);
        wr(12'hF00, 32'h0000_01FF);
        chk("R12 511 rejected", {31'h0, p_trig}, 32'h0);
        wr(12'hF00, 32'hFFFF_FE05);
        chk("R12 upper bits ignored", {22'h0, p_trig, p_irq}, {22'h0, 1'b1, 9'd5});
    endtask

    bit done = 1'b0;

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_set();
        t_clear();
        t_fields();
        t_race();
        t_handler();
        t_enables();
        t_vbase();
        t_rstctl();
        t_trig();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule